// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Port

This block is a passive byte-wide slave port through which an external host moves 16-bit words to and from a processor core. The host provides every strobe. A four-bit configuration word selects one of two bus styles. The first style uses separate active-low write and read strobes. The second uses one data strobe, whose active level can be programmed, together with a read/write line. The configuration also sets the active level of the byte-select pin and switches between 16-bit word transfers and 8-bit transfers.

All host pins pass through a two-flop synchronizer into the core clock. An access ends on the cycle after the synchronized strobe is released. The core side has a 16-bit input word with an input-full flag, and a 16-bit output word with an output-empty flag. The core loads the output word and acknowledges the input word with single-cycle pulses. A status-select pin makes a host read return a flag byte instead of data. Each strobe style can raise its own interrupt pulse toward the core when the strobe is asserted.

Top module: `hport_top`

## Requirements
- R1: Synchronous active-high reset clears input-full, sets output-empty, clears host read data and its enable, and clears both interrupt pulses.
- R2: With cfg_ctrl bit 1 = 0, pin_a is an active-low host write strobe and pin_b is an active-low host read strobe. With bit 1 = 1, pin_b is the data strobe and pin_a is the direction line (1 = read, 0 = write).
- R3: In the second style, cfg_ctrl bit 2 gives the active level of the data strobe (1 = active high, 0 = active low).
- R4: In 16-bit mode (cfg_ctrl bit 0 = 1) the high byte lane is addressed when host_bsel XOR cfg_ctrl bit 3 equals 1. Otherwise the low lane is addressed.
- R5: In 16-bit mode a flag changes only on an access made with host_bsel = 1. That is the high byte when bit 3 = 0 and the low byte when bit 3 = 1. A write sets input-full and a read sets output-empty.
- R6: In 8-bit mode (bit 0 = 0) only the low lane is accessed, whatever host_bsel is, and every completed access updates its flag.
- R7: While host_cs_n is high, strobe activity changes no buffer, flag, read data or interrupt.
- R8: A read with host_stat_sel = 1 returns a status byte with bit 0 = input-full, bit 1 = output-empty and the other bits 0. Such a read changes no flag.
- R9: A core_rd pulse clears input-full. A core_wr pulse loads core_wdata into the output word and clears output-empty.
- R10: With host_cs_n low, asserting the write strobe gives a one-cycle irq_wr pulse if irq_en bit 0 = 1. Asserting the read strobe gives an irq_rd pulse if irq_en bit 1 = 1.
- R11: An access completes only when its strobe is released. Flags do not change while the strobe is held. Write data is the value present on host_din while the strobe was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctrl | input | 4 | bit0 word mode, bit1 bus style, bit2 data-strobe level, bit3 byte-select level |
| irq_en | input | 2 | bit0 write-strobe interrupt enable, bit1 read-strobe interrupt enable |
| host_cs_n | input | 1 | Active-low chip select |
| host_pin_a | input | 1 | Write strobe (style 0) or read/write line (style 1) |
| host_pin_b | input | 1 | Read strobe (style 0) or data strobe (style 1) |
| host_bsel | input | 1 | Byte-lane select |
| host_stat_sel | input | 1 | Selects the status byte on reads |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data, registered |
| host_doe | output | 1 | High while a host read is active |
| core_rd | input | 1 | Core acknowledges the input word |
| core_wr | input | 1 | Core loads the output word |
| core_wdata | input | 16 | Word for the host to read |
| in_word | output | 16 | Word assembled from host writes |
| in_full | output | 1 | Input-full flag |
| out_empty | output | 1 | Output-empty flag |
| irq_wr | output | 1 | Write-strobe interrupt pulse |
| irq_rd | output | 1 | Read-strobe interrupt pulse |

## Verification
The bench goes after the two byte-select levels. A design that mixed up the lane decode with the flag byte would assemble swapped words, or would raise input-full after the first byte instead of the second. It runs both bus styles with both data-strobe levels. An inverted level would make an idle bus look like a continuous access, and the data would never complete. Narrow mode is driven with host_bsel high to catch a design that still steers bytes into the high lane. Status reads, strobes with chip select high and strobes held for many cycles are checked too. These catch a design that clears flags on a status read, accepts deselected traffic, or completes an access on the leading edge of the strobe.

// File: rtl/hport_pkg.sv
package hport_pkg;
  // Configuration word; bit order is the order the host programs it in.
  typedef struct packed {
    logic bspol;  // bit 3: byte-select level
    logic dspol;  // bit 2: data-strobe level, second bus style
    logic proto;  // bit 1: bus style
    logic wide;   // bit 0: 16-bit transfers
  } hport_cfg_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL[i];
        stage2[i] <= RST_VAL[i];
      end else begin
        stage1[i] <= d_async[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/hport_decode.sv
module hport_decode
  import hport_pkg::*;
#(
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  hport_cfg_t        cfg,
  input  logic              cs_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              bsel,
  input  logic              stat_sel,
  input  logic [HOST_W-1:0] din,
  output logic              rd_act,
  output logic              wr_start,
  output logic              rd_start,
  output logic              wr_done,
  output logic              rd_done,
  output logic              lane_hi,
  output logic              lat_hi,
  output logic              lat_fin,
  output logic              lat_stat,
  output logic [HOST_W-1:0] lat_byte
);
  logic ds_on, wr_now, rd_now, wr_q, rd_q, fin_now;

  // Data strobe of the second style carries a programmable level.
  assign ds_on   = ~(pin_b ^ cfg.dspol);
  assign wr_now  = ~cs_n & (cfg.proto ? (ds_on & ~pin_a) : ~pin_a);
  assign rd_now  = ~cs_n & (cfg.proto ? (ds_on &  pin_a) : ~pin_b);
  assign lane_hi = cfg.wide & (bsel ^ cfg.bspol);
  assign fin_now = ~cfg.wide | bsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      lat_hi   <= 1'b0;
      lat_fin  <= 1'b0;
      lat_stat <= 1'b0;
      lat_byte <= '0;
    end else begin
      wr_q <= wr_now;
      rd_q <= rd_now;
      if (wr_now) lat_byte <= din;
      if (wr_now | rd_now) begin
        lat_hi   <= lane_hi;
        lat_fin  <= fin_now;
        lat_stat <= stat_sel & rd_now;
      end
    end
  end

  assign rd_act   = rd_now;
  assign wr_start = wr_now & ~wr_q;
  assign rd_start = rd_now & ~rd_q;
  assign wr_done  = wr_q & ~wr_now;
  assign rd_done  = rd_q & ~rd_now;
endmodule

// File: rtl/hport_buffers.sv
module hport_buffers #(
  parameter int HOST_W = 8,
  localparam int WORD_W = 2 * HOST_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              lat_hi,
  input  logic              lat_fin,
  input  logic              lat_stat,
  input  logic [HOST_W-1:0] lat_byte,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [WORD_W-1:0] core_wdata,
  output logic [WORD_W-1:0] in_word,
  output logic [WORD_W-1:0] out_word,
  output logic              ibf,
  output logic              obe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_word <= '0;
      ibf     <= 1'b0;
    end else begin
      if (wr_done) begin
        if (lat_hi) in_word[WORD_W-1:HOST_W] <= lat_byte;
        else        in_word[HOST_W-1:0]      <= lat_byte;
      end
      if (wr_done && lat_fin) ibf <= 1'b1;
      else if (core_rd)       ibf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      obe      <= 1'b1;
    end else if (core_wr) begin
      out_word <= core_wdata;
      obe      <= 1'b0;
    end else if (rd_done && lat_fin && !lat_stat) begin
      obe <= 1'b1;
    end
  end

  // R9
  core_wr_clears_obe_chk: assert property (@(posedge clk) disable iff (rst)
    core_wr |=> !obe);
  // R9
  core_rd_clears_ibf_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rd && !wr_done) |=> !ibf);
  // R11
  ibf_set_by_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(wr_done));
  // R11
  obe_set_by_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(obe) |-> $past(rd_done));
  // R1
  reset_flags_chk: assert property (@(posedge clk)
    rst |=> (obe && !ibf));
endmodule

// File: rtl/hport_top.sv
module hport_top
  import hport_pkg::*;
#(
  parameter int HOST_W = 8,
  localparam int WORD_W = 2 * HOST_W,
  localparam int SYNC_W = HOST_W + 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cfg_ctrl,
  input  logic [1:0]        irq_en,
  input  logic              host_cs_n,
  input  logic              host_pin_a,
  input  logic              host_pin_b,
  input  logic              host_bsel,
  input  logic              host_stat_sel,
  input  logic [HOST_W-1:0] host_din,
  output logic [HOST_W-1:0] host_dout,
  output logic              host_doe,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [WORD_W-1:0] core_wdata,
  output logic [WORD_W-1:0] in_word,
  output logic              in_full,
  output logic              out_empty,
  output logic              irq_wr,
  output logic              irq_rd
);
  localparam logic [SYNC_W-1:0] SYNC_RST = {5'b11111, {HOST_W{1'b0}}};

  hport_cfg_t        cfg;
  logic [SYNC_W-1:0] raw_v, syn_v;
  logic              cs_s, a_s, b_s, bsel_s, stat_s;
  logic [HOST_W-1:0] din_s;
  logic              rd_act, wr_start, rd_start, wr_done, rd_done;
  logic              lane_hi, lat_hi, lat_fin, lat_stat;
  logic [HOST_W-1:0] lat_byte;
  logic [WORD_W-1:0] out_word;
  logic              ibf, obe;

  assign cfg   = cfg_ctrl;
  assign raw_v = {host_stat_sel, host_bsel, host_pin_b, host_pin_a, host_cs_n, host_din};
  assign {stat_s, bsel_s, b_s, a_s, cs_s, din_s} = syn_v;

  hport_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_v), .d_sync(syn_v));

  hport_decode #(.HOST_W(HOST_W)) u_dec (
    .clk(clk), .rst(rst), .cfg(cfg), .cs_n(cs_s), .pin_a(a_s), .pin_b(b_s),
    .bsel(bsel_s), .stat_sel(stat_s), .din(din_s), .rd_act(rd_act),
    .wr_start(wr_start), .rd_start(rd_start), .wr_done(wr_done), .rd_done(rd_done),
    .lane_hi(lane_hi), .lat_hi(lat_hi), .lat_fin(lat_fin), .lat_stat(lat_stat),
    .lat_byte(lat_byte));

  hport_buffers #(.HOST_W(HOST_W)) u_buf (
    .clk(clk), .rst(rst), .wr_done(wr_done), .rd_done(rd_done), .lat_hi(lat_hi),
    .lat_fin(lat_fin), .lat_stat(lat_stat), .lat_byte(lat_byte), .core_rd(core_rd),
    .core_wr(core_wr), .core_wdata(core_wdata), .in_word(in_word),
    .out_word(out_word), .ibf(ibf), .obe(obe));

  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
      host_doe  <= 1'b0;
      irq_wr    <= 1'b0;
      irq_rd    <= 1'b0;
    end else begin
      host_doe <= rd_act;
      irq_wr   <= wr_start & irq_en[0];
      irq_rd   <= rd_start & irq_en[1];
      if (rd_act) begin
        if (stat_s)       host_dout <= {{(HOST_W-2){1'b0}}, obe, ibf};
        else if (lane_hi) host_dout <= out_word[WORD_W-1:HOST_W];
        else              host_dout <= out_word[HOST_W-1:0];
      end
    end
  end

  assign in_full   = ibf;
  assign out_empty = obe;

  // R10
  irq_wr_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    irq_wr |-> $past(irq_en[0]));
  // R10
  irq_rd_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    irq_rd |-> $past(irq_en[1]));
  // R7
  irq_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_wr || irq_rd) |-> !$past(cs_s));
endmodule

// File: tb/hport_top_test.sv
module hport_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_ctrl = 4'b0001;
  logic [1:0]  irq_en = 2'b00;
  logic        cs_n = 1'b1, pin_a = 1'b1, pin_b = 1'b1, bsel = 1'b0, stat_sel = 1'b0;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        doe, core_rd = 1'b0, core_wr = 1'b0;
  logic [15:0] core_wdata = 16'h0000, in_word;
  logic        in_full, out_empty, irq_wr, irq_rd;

  int checks = 0, fails = 0, cycles = 0, n_irq_wr = 0, n_irq_rd = 0;
  logic [7:0] rdata;
  logic mid_ibf, mid_obe;

  always #2 clk = ~clk;

  hport_top uut (
    .clk(clk), .rst(rst), .cfg_ctrl(cfg_ctrl), .irq_en(irq_en), .host_cs_n(cs_n),
    .host_pin_a(pin_a), .host_pin_b(pin_b), .host_bsel(bsel), .host_stat_sel(stat_sel),
    .host_din(din), .host_dout(dout), .host_doe(doe), .core_rd(core_rd),
    .core_wr(core_wr), .core_wdata(core_wdata), .in_word(in_word), .in_full(in_full),
    .out_empty(out_empty), .irq_wr(irq_wr), .irq_rd(irq_rd));

  always @(negedge clk) begin
    if (!rst && irq_wr) n_irq_wr++;
    if (!rst && irq_rd) n_irq_rd++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ctrl, bsel, din, expected in_full, expected word
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0001, 1'b0, 8'h34, 1'b0, 16'h0000},
    {4'b0001, 1'b1, 8'h12, 1'b1, 16'h1234},
    {4'b1001, 1'b0, 8'hAB, 1'b0, 16'h0000},
    {4'b1001, 1'b1, 8'hCD, 1'b1, 16'hABCD},
    {4'b0000, 1'b1, 8'h5A, 1'b1, 16'hAB5A},
    {4'b0011, 1'b0, 8'h78, 1'b0, 16'h0000},
    {4'b0011, 1'b1, 8'h56, 1'b1, 16'h5678},
    {4'b0111, 1'b0, 8'hEF, 1'b0, 16'h0000},
    {4'b0111, 1'b1, 8'hBE, 1'b1, 16'hBEEF},
    {4'b1110, 1'b0, 8'h99, 1'b1, 16'hBE99}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_access(input logic [3:0] c, input logic wr, input logic sel_n,
                             input logic bs, input logic st, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b1; cfg_ctrl = c; pin_a = 1'b1; pin_b = c[1] ? ~c[2] : 1'b1;
    bsel = bs; stat_sel = st; din = d;
    repeat (3) @(negedge clk);
    cs_n = sel_n;
    repeat (2) @(negedge clk);
    if (!c[1]) begin
      if (wr) pin_a = 1'b0; else pin_b = 1'b0;
    end else begin
      pin_a = ~wr;
      repeat (2) @(negedge clk);
      pin_b = c[2];
    end
    repeat (8) @(negedge clk);
    rdata = dout; mid_ibf = in_full; mid_obe = out_empty;
    if (!c[1]) begin pin_a = 1'b1; pin_b = 1'b1; end
    else pin_b = ~c[2];
    repeat (5) @(negedge clk);
    cs_n = 1'b1; pin_a = 1'b1; stat_sel = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic core_load(input logic [15:0] w);
    @(negedge clk); core_wr = 1'b1; core_wdata = w;
    @(negedge clk); core_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic core_take();
    @(negedge clk); core_rd = 1'b1;
    @(negedge clk); core_rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(in_full == 1'b0, "R1 in_full", 32'(in_full), 0);
    chk(out_empty == 1'b1, "R1 out_empty", 32'(out_empty), 1);
    chk(dout == 8'h00 && !doe, "R1 dout/doe", {23'b0, doe, dout}, 0);
    chk(!irq_wr && !irq_rd, "R1 irq", {30'b0, irq_wr, irq_rd}, 0);

    // R2 R3 R4 R5 R6 host writes from the table
    for (int i = 0; i < NV; i++) begin
      host_access(VEC[i][29:26], 1'b1, 1'b0, VEC[i][25], 1'b0, VEC[i][24:17]);
      chk(in_full == VEC[i][16], $sformatf("R5 write vector %0d in_full", i),
          32'(in_full), 32'(VEC[i][16]));
      if (VEC[i][16]) begin
        chk(in_word == VEC[i][15:0], $sformatf("R4 write vector %0d word", i),
            32'(in_word), 32'(VEC[i][15:0]));
        core_take();
        chk(in_full == 1'b0, "R9 core_rd clears in_full", 32'(in_full), 0);
      end
    end

    // R9 core load, then wide reads in the first style
    core_load(16'hC3A5);
    chk(out_empty == 1'b0, "R9 core_wr clears out_empty", 32'(out_empty), 0);
    host_access(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(rdata == 8'hA5, "R4 low lane read", 32'(rdata), 32'hA5);
    chk(out_empty == 1'b0, "R5 no flag on non-final byte", 32'(out_empty), 0);
    host_access(4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk(rdata == 8'hC3, "R4 high lane read", 32'(rdata), 32'hC3);
    chk(out_empty == 1'b1, "R5 flag on final byte", 32'(out_empty), 1);

    // R3 second style, active-high data strobe, inverted byte select
    core_load(16'h6E91);
    host_access(4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(rdata == 8'h6E, "R3 high lane via bsel low", 32'(rdata), 32'h6E);
    chk(out_empty == 1'b0, "R5 high byte not final", 32'(out_empty), 0);
    host_access(4'b1111, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk(rdata == 8'h91, "R3 low lane via bsel high", 32'(rdata), 32'h91);
    chk(out_empty == 1'b1, "R5 low byte final", 32'(out_empty), 1);

    // R6 narrow read ignores bsel
    core_load(16'h1177);
    host_access(4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk(rdata == 8'h77, "R6 narrow read low lane", 32'(rdata), 32'h77);
    chk(out_empty == 1'b1, "R6 narrow read sets flag", 32'(out_empty), 1);

    // R11 flag held until strobe release; R8 status read
    host_access(4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
    chk(mid_ibf == 1'b0, "R11 no flag while strobe held", 32'(mid_ibf), 0);
    chk(in_full == 1'b1 && in_word[7:0] == 8'h3C, "R11 write completes at release",
        {15'b0, in_full, in_word}, {15'b0, 1'b1, in_word[15:8], 8'h3C});
    host_access(4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk(rdata == 8'h03, "R8 status byte", 32'(rdata), 32'h03);
    chk(in_full == 1'b1 && out_empty == 1'b1, "R8 status read leaves flags",
        {30'b0, in_full, out_empty}, 32'h3);
    core_take();
    core_load(16'h2468);
    host_access(4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    chk(rdata == 8'h00, "R8 status byte both clear", 32'(rdata), 0);
    chk(out_empty == 1'b0, "R8 status read keeps out_empty low", 32'(out_empty), 0);

    // R7 deselected write and read
    host_access(4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'hEE);
    chk(in_full == 1'b0 && in_word[7:0] == 8'h3C, "R7 write ignored",
        {15'b0, in_full, in_word}, {15'b0, 1'b0, in_word[15:8], 8'h3C});
    host_access(4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk(out_empty == 1'b0 && !doe, "R7 read ignored", {30'b0, out_empty, doe}, 0);

    // R10 interrupts
    irq_en = 2'b11;
    host_access(4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h42);
    chk(n_irq_wr == 1, "R10 write irq", 32'(n_irq_wr), 1);
    host_access(4'b0011, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    chk(n_irq_rd == 1, "R10 read irq", 32'(n_irq_rd), 1);
    host_access(4'b0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h42);
    chk(n_irq_wr == 1, "R7 no irq while deselected", 32'(n_irq_wr), 1);
    irq_en = 2'b00;
    host_access(4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h43);
    chk(n_irq_wr == 1, "R10 irq disabled", 32'(n_irq_wr), 1);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(in_full == 1'b0 && out_empty == 1'b1, "R1 flags after reset",
        {30'b0, in_full, out_empty}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule